// File: doc/BRIEF.md
# Network Descriptor Pointer Walker

This block turns a pair of identifiers, an address-space number and a network number, into the memory address of one network's configuration record. The operating system keeps a two-level table in memory. The first level has one three-word record per address space. Word 0 of that record points to the space's slot array, word 1 points to its I/O queue area, and word 2 holds the number of networks the space owns. The second level is the slot array, with one word per network, and each word holds a configuration pointer. Identifiers are assigned from zero upward, so the walker reaches a record directly by index arithmetic and never searches.

Supervisor software loads two registers through a small write port: the table base and the number of valid address spaces. A client presents an identifier pair on a valid/ready request port. One cycle later the walker drops ready and chases the pointers through a single-outstanding read port. Memory may stall the request and may return data after any number of cycles. At the end the walker returns either the configuration pointer or an error code that names which index was out of range. It handles one request at a time.

Top module: `idtab_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_req_valid is 0, and the address-space count register is 0. A request made before any supervisor write therefore ends with rsp_code 1.
- R2: A supervisor write with sup_sel=0 loads the table base and one with sup_sel=1 loads the address-space count. The new value applies to requests accepted on later clock edges.
- R3: If req_asid is greater than or equal to the address-space count, the response has rsp_code 1, rsp_err 1 and rsp_ptr 0, and the walker issues no memory read for that request.
- R4: If the address space is in range and req_nnid is greater than or equal to the word at entry+2, the response has rsp_code 2, rsp_err 1 and rsp_ptr 0. Entry+2 is then the only address read, where entry = base + 3*asid.
- R5: Otherwise the walker reads exactly three word addresses in this order: entry+2, entry+0, and then (word at entry+0)+nnid. The response has rsp_code 0, rsp_err 0, and rsp_ptr equal to the last word read.
- R6: req_ready is 1 exactly when the walker is idle. It is 0 from the cycle after a request is accepted through the cycle of the response. Each accepted request produces exactly one rsp_valid pulse, one cycle wide.
- R7: Once mem_req_valid rises, it and mem_req_addr stay stable until a cycle with mem_req_ready high. No new read is requested until the previous read's data has returned.
- R8: Results do not depend on how long memory stalls a request or how many cycles (at least one) it takes to return data.
- R9: A walk uses the base and count held before the edge that accepts its request. A supervisor write on that same edge, or during the walk, affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_we | input | 1 | Supervisor register write strobe |
| sup_sel | input | 1 | 0 selects the table base, 1 selects the address-space count |
| sup_wdata | input | ADDR_W | Supervisor write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_asid | input | ASID_W | Address-space number |
| req_nnid | input | NNID_W | Network number within the address space |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is an error |
| rsp_code | output | 2 | 0 ok, 1 address space out of range, 2 network out of range |
| rsp_ptr | output | DATA_W | Configuration pointer, 0 on error |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | ADDR_W | Word address to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DATA_W | Read data |

## Verification
Two things can land on the same clock edge: a supervisor register write and the acceptance of a request. The bench drives both strobes in one cycle, once rewriting the count to zero and once moving the base to a second table. It then expects the walk to follow the old values and the next request to follow the new ones. A second collision happens inside the walk: a memory response can arrive in the same cycle the walker would start its next read. The bench provokes this with random ready stalls and zero-extra-cycle responses, and it judges the result by comparing every read address against the queue of addresses that the bench's own model of the table predicts.

// File: rtl/idtab_pkg.sv
package idtab_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_ASID_ENT  = 2'd1,
    ST_NNID_SLOT = 2'd2,
    ST_RESPOND   = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    RC_OK       = 2'd0,
    RC_BAD_ASID = 2'd1,
    RC_BAD_NNID = 2'd2
  } rsp_code_e;

  localparam int unsigned ENTRY_WORDS = 3;
  localparam int unsigned OFS_ARRAY   = 0;
  localparam int unsigned OFS_IOQ     = 1;
  localparam int unsigned OFS_COUNT   = 2;

endpackage

// File: rtl/idtab_sup_regs.sv
module idtab_sup_regs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_we,
  input  logic              sup_sel,
  input  logic [ADDR_W-1:0] sup_wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] acnt_q
);

  wire base_wr = sup_we && !sup_sel;
  wire cnt_wr  = sup_we &&  sup_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      acnt_q <= '0;
    end else begin
      if (base_wr) base_q <= sup_wdata;
      if (cnt_wr)  acnt_q <= sup_wdata;
    end
  end

  AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> base_q == $past(sup_wdata)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> acnt_q == $past(sup_wdata)); // R2
  AST_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> $stable(acnt_q)); // R2

endmodule

// File: rtl/idtab_rd_chan.sv
module idtab_rd_chan #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_addr,
  output logic              rd_busy,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  logic              pend_q;
  logic              wait_q;
  logic [ADDR_W-1:0] addr_q;

  wire req_hs = pend_q && mem_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wait_q <= 1'b0;
      addr_q <= '0;
    end else begin
      if (issue) begin
        pend_q <= 1'b1;
        addr_q <= issue_addr;
      end else if (req_hs) begin
        pend_q <= 1'b0;
        wait_q <= 1'b1;
      end
      if (rd_done) wait_q <= 1'b0;
    end
  end

  assign mem_req_valid = pend_q;
  assign mem_req_addr  = addr_q;
  assign rd_done       = wait_q && mem_rsp_valid;
  assign rd_data       = mem_rsp_data;
  assign rd_busy       = pend_q || wait_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R7
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !rd_busy); // R7
  AST_NO_REQ_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !mem_req_valid); // R7

endmodule

// File: rtl/idtab_walk_fsm.sv
module idtab_walk_fsm
  import idtab_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ASID_W = 8,
  parameter int NNID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [NNID_W-1:0] req_nnid,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [ADDR_W-1:0] acnt_q,
  output logic              issue,
  output logic [ADDR_W-1:0] issue_addr,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [DATA_W-1:0] rsp_ptr
);

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [ASID_W-1:0] asid);
    return base + ADDR_W'(asid) * ADDR_W'(ENTRY_WORDS);
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [DATA_W-1:0] arr,
                                                  input logic [NNID_W-1:0] nnid);
    return ADDR_W'(arr) + ADDR_W'(nnid);
  endfunction

  walk_state_e       state_q;
  logic              phase_q;
  logic              rd_open_q;
  logic [ADDR_W-1:0] ent_q;
  logic [ADDR_W-1:0] slot_q;
  logic [NNID_W-1:0] nnid_q;
  rsp_code_e         code_q;
  logic [DATA_W-1:0] ptr_q;

  wire in_read     = (state_q == ST_ASID_ENT) || (state_q == ST_NNID_SLOT);
  wire acc_fire    = req_valid && (state_q == ST_IDLE);
  wire asid_ok     = ADDR_W'(req_asid) < acnt_q;
  wire asid_reject = acc_fire && !asid_ok;
  wire cnt_done    = rd_done && (state_q == ST_ASID_ENT) && !phase_q;
  wire nnid_reject = cnt_done && (DATA_W'(nnid_q) >= rd_data);
  wire arr_done    = rd_done && (state_q == ST_ASID_ENT) && phase_q;
  wire slot_done   = rd_done && (state_q == ST_NNID_SLOT);

  assign issue = in_read && !rd_open_q;

  always_comb begin
    issue_addr = slot_q;
    if (state_q == ST_ASID_ENT) begin
      if (phase_q) issue_addr = ent_q + ADDR_W'(OFS_ARRAY);
      else         issue_addr = ent_q + ADDR_W'(OFS_COUNT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= 1'b0;
      rd_open_q <= 1'b0;
      ent_q     <= '0;
      slot_q    <= '0;
      nnid_q    <= '0;
      code_q    <= RC_OK;
      ptr_q     <= '0;
    end else begin
      if (issue)   rd_open_q <= 1'b1;
      if (rd_done) rd_open_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (acc_fire) begin
            nnid_q  <= req_nnid;
            ent_q   <= entry_addr(base_q, req_asid);
            phase_q <= 1'b0;
            if (asid_ok) begin
              state_q <= ST_ASID_ENT;
            end else begin
              code_q  <= RC_BAD_ASID;
              ptr_q   <= '0;
              state_q <= ST_RESPOND;
            end
          end
        end
        ST_ASID_ENT: begin
          if (nnid_reject) begin
            code_q  <= RC_BAD_NNID;
            ptr_q   <= '0;
            state_q <= ST_RESPOND;
          end else if (cnt_done) begin
            phase_q <= 1'b1;
          end else if (arr_done) begin
            slot_q  <= slot_addr(rd_data, nnid_q);
            state_q <= ST_NNID_SLOT;
          end
        end
        ST_NNID_SLOT: begin
          if (slot_done) begin
            code_q  <= RC_OK;
            ptr_q   <= rd_data;
            state_q <= ST_RESPOND;
          end
        end
        ST_RESPOND: state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESPOND);
  assign rsp_code  = code_q;
  assign rsp_ptr   = ptr_q;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> !req_ready); // R6
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready); // R6
  AST_ASID_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    asid_reject |=> rsp_valid && rsp_code == RC_BAD_ASID && !issue); // R3
  AST_NNID_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    nnid_reject |=> rsp_valid && rsp_code == RC_BAD_NNID); // R4
  AST_ERR_NULL_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code != RC_OK |-> rsp_ptr == '0); // R3
  AST_SLOT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done |=> rsp_valid && rsp_ptr == $past(rd_data)); // R5

endmodule

// File: rtl/idtab_walker.sv
module idtab_walker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ASID_W = 8,
  parameter int NNID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_we,
  input  logic              sup_sel,
  input  logic [ADDR_W-1:0] sup_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [NNID_W-1:0] req_nnid,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [1:0]        rsp_code,
  output logic [DATA_W-1:0] rsp_ptr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] acnt_q;
  logic              issue;
  logic [ADDR_W-1:0] issue_addr;
  logic              rd_busy;
  logic              rd_done;
  logic [DATA_W-1:0] rd_data;

  idtab_sup_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sup_we    (sup_we),
    .sup_sel   (sup_sel),
    .sup_wdata (sup_wdata),
    .base_q    (base_q),
    .acnt_q    (acnt_q)
  );

  idtab_walk_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ASID_W (ASID_W),
    .NNID_W (NNID_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_asid   (req_asid),
    .req_nnid   (req_nnid),
    .base_q     (base_q),
    .acnt_q     (acnt_q),
    .issue      (issue),
    .issue_addr (issue_addr),
    .rd_done    (rd_done),
    .rd_data    (rd_data),
    .rsp_valid  (rsp_valid),
    .rsp_code   (rsp_code),
    .rsp_ptr    (rsp_ptr)
  );

  idtab_rd_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue         (issue),
    .issue_addr    (issue_addr),
    .rd_busy       (rd_busy),
    .rd_done       (rd_done),
    .rd_data       (rd_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
  );

  assign rsp_err = (rsp_code != 2'd0);

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rd_busy); // R6
  AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R3

endmodule

// File: tb/idtab_walker_test.sv
module idtab_walker_test;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = 8;
  localparam int NW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          sup_we = 1'b0, sup_sel = 1'b0;
  logic [AW-1:0] sup_wdata = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [SW-1:0] req_asid = '0;
  logic [NW-1:0] req_nnid = '0;
  logic          rsp_valid, rsp_err;
  logic [1:0]    rsp_code;
  logic [DW-1:0] rsp_ptr;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;

  idtab_walker #(.ADDR_W(AW), .DATA_W(DW), .ASID_W(SW), .NNID_W(NW)) uut (.*);

  logic [31:0] mem [256];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int unsigned exp_addr[$];
  int unsigned exp_ptr;
  int unsigned exp_code;
  bit          busy = 1'b0;
  int unsigned m_base = 0;
  int unsigned m_cnt  = 0;
  string       tag = "R1";

  bit          pend = 1'b0;
  int unsigned pend_addr;
  int unsigned pend_wait;
  bit          fast_mem = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned rd(input int unsigned a);
    return int'(mem[a % 256]);
  endfunction

  // Own model of the two-level table lookup
  function automatic void predict(input int unsigned asid, input int unsigned nnid);
    int unsigned rec, owned, arr;
    exp_addr.delete();
    exp_ptr = 0;
    if (asid >= m_cnt) begin
      exp_code = 1;
      return;
    end
    rec = m_base + asid * 3;
    exp_addr.push_back(rec + 2);
    owned = rd(rec + 2);
    if (nnid >= owned) begin
      exp_code = 2;
      return;
    end
    exp_addr.push_back(rec);
    arr = rd(rec);
    exp_addr.push_back(arr + nnid);
    exp_ptr  = rd(arr + nnid);
    exp_code = 0;
  endfunction

  // Per-cycle monitor, reference model and memory
  always @(negedge clk) begin
    bit nr;
    if (rst_n) begin
      check(req_ready == !busy, "R6", "req_ready", req_ready, !busy);
      if (rsp_valid) begin
        check(busy, "R6", "unexpected rsp_valid", 1, 0);
        check(exp_addr.size() == 0, tag, "reads left at response", exp_addr.size(), 0);
        check(rsp_code == exp_code, tag, "rsp_code", rsp_code, exp_code);
        check(rsp_ptr == exp_ptr, tag, "rsp_ptr", rsp_ptr, exp_ptr);
        check(rsp_err == (exp_code != 0), tag, "rsp_err", rsp_err, exp_code != 0);
        busy = 1'b0;
      end
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (pend_wait == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem[pend_addr % 256];
          pend = 1'b0;
        end else begin
          pend_wait--;
        end
      end
      nr = fast_mem ? 1'b1 : (($urandom % 10) < 6);
      if (pend || mem_rsp_valid) nr = 1'b0;
      if (mem_req_valid && nr) begin
        if (exp_addr.size() == 0) begin
          check(1'b0, tag, "read with none expected", mem_req_addr, 0);
        end else begin
          check(mem_req_addr == exp_addr[0], tag, "read address", mem_req_addr, exp_addr[0]);
          void'(exp_addr.pop_front());
        end
        pend = 1'b1;
        pend_addr = mem_req_addr;
        pend_wait = fast_mem ? 0 : ($urandom % 4);
      end
      mem_req_ready = nr;
      if (req_valid && req_ready) begin
        predict(req_asid, req_nnid);
        busy = 1'b1;
      end
      if (sup_we) begin
        if (sup_sel) m_cnt = sup_wdata;
        else         m_base = sup_wdata;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic sup_write(input bit sel, input int unsigned val);
    @(posedge clk); #1;
    sup_we = 1'b1; sup_sel = sel; sup_wdata = val;
    @(posedge clk); #1;
    sup_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(posedge clk);
  endtask

  task automatic run_req(input string t, input int unsigned a, input int unsigned n);
    @(posedge clk); #1;
    tag = t;
    req_valid = 1'b1; req_asid = a[SW-1:0]; req_nnid = n[NW-1:0];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    wait_idle();
  endtask

  // Request and supervisor write on the same accepting edge
  task automatic run_req_with_write(input int unsigned a, input int unsigned n,
                                    input bit sel, input int unsigned val);
    @(posedge clk); #1;
    tag = "R9";
    req_valid = 1'b1; req_asid = a[SW-1:0]; req_nnid = n[NW-1:0];
    sup_we = 1'b1; sup_sel = sel; sup_wdata = val;
    @(posedge clk); #1;
    req_valid = 1'b0; sup_we = 1'b0;
    wait_idle();
  endtask

  // Supervisor write in the middle of a walk
  task automatic run_req_then_write(input int unsigned a, input int unsigned n,
                                    input bit sel, input int unsigned val);
    @(posedge clk); #1;
    tag = "R9";
    req_valid = 1'b1; req_asid = a[SW-1:0]; req_nnid = n[NW-1:0];
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(posedge clk); #1;
    sup_we = 1'b1; sup_sel = sel; sup_wdata = val;
    @(posedge clk); #1;
    sup_we = 1'b0;
    wait_idle();
  endtask

  task automatic put_rec(input int unsigned at, input int unsigned arr,
                         input int unsigned ioq, input int unsigned cnt);
    mem[at]     = arr;
    mem[at + 1] = ioq;
    mem[at + 2] = cnt;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 | i;
    put_rec(16, 64, 200, 4);
    put_rec(19, 80, 210, 2);
    put_rec(22, 96, 220, 0);
    put_rec(25, 112, 230, 3);
    put_rec(28, 120, 240, 5);
    put_rec(160, 176, 0, 2);
    put_rec(163, 180, 0, 1);
    for (int i = 64; i < 130; i++) mem[i] = 32'hC0DE_0000 | i;
    for (int i = 176; i < 184; i++) mem[i] = 32'hBEEF_0000 | i;

    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    check(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", mem_req_valid, 0);
    run_req("R1", 0, 0);

    sup_write(1'b0, 16);
    sup_write(1'b1, 3);
    run_req("R2", 0, 0);
    run_req("R5", 0, 3);
    run_req("R5", 1, 1);
    run_req("R4", 2, 0);
    run_req("R3", 3, 0);
    run_req("R3", 200, 0);
    run_req("R4", 0, 4);
    run_req("R4", 1, 2);
    run_req("R4", 0, 255);
    sup_write(1'b1, 4);
    run_req("R2", 3, 2);

    run_req_with_write(3, 1, 1'b1, 0);
    run_req("R9", 0, 0);
    sup_write(1'b1, 4);
    run_req_with_write(0, 1, 1'b0, 160);
    run_req("R9", 1, 0);
    run_req_then_write(0, 1, 1'b0, 16);
    run_req("R9", 1, 1);

    fast_mem = 1'b1;
    run_req("R8", 0, 2);
    run_req("R8", 3, 0);
    fast_mem = 1'b0;

    sup_write(1'b1, 5);
    for (int k = 0; k < 80; k++) begin
      fast_mem = (k % 5 == 0);
      run_req("R8", $urandom % 7, $urandom % 7);
    end
    fast_mem = 1'b0;

    repeat (5) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule